// File: doc/BRIEF.md
# Pad Power Clamp Sequencer

This block drives the three isolation controls of a group of I/O pads: a core power-down flag, an early clamp and a final clamp. Several clients share the pads, so the block keeps a reference count of them. Each client sends a one-cycle enable pulse when it needs the pads and a one-cycle disable pulse when it is done.

The first enable, which takes the count from zero to one, starts a power-up. The power-up releases the final clamp, then the early clamp, then core power-down, with a fixed gap between steps. The last disable, which takes the count from one to zero, starts a power-down. The power-down reasserts the same three controls in the mirror order, with the same gap.

A disable that arrives when the count is already zero does not change the count. It produces a one-cycle error pulse instead. A force-off input empties the count at once, so the pads end clamped. The gap is measured in microsecond ticks taken from a prescaler, so one gap lasts `GAP_US * CLKS_PER_US` clock cycles. The three controls also appear in the top three bits of a 32-bit control word. The other bits of that word pass through unchanged.

Top module: `pad_clamp_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, core_pd_o, early_clamp_o and clamp_o are all 1. In the same conditions busy_o and err_o are 0.
- R2: An enable pulse at count 0 drops clamp_o one cycle after the sampling edge. early_clamp_o falls G = GAP_US*CLKS_PER_US cycles later, and core_pd_o falls G cycles after that. busy_o is 1 from the first step until core_pd_o falls.
- R3: An enable pulse at a non-zero count only increments the count and leaves all outputs unchanged.
- R4: A disable pulse that takes the count from 1 to 0 raises core_pd_o one cycle after the sampling edge. early_clamp_o rises G cycles later and clamp_o rises G cycles after that. busy_o is 1 from the first step until clamp_o rises.
- R5: A disable pulse at a count above 1 only decrements the count and leaves all outputs unchanged.
- R6: A disable pulse at count 0 makes err_o 1 for exactly the one cycle after the sampling edge. The count stays at 0, so the next enable starts a power-up and one disable then powers down again.
- R7: word_out equals word_in, except that bit 31 carries core_pd_o, bit 30 carries early_clamp_o and bit 29 carries clamp_o.
- R8: force_off at 1 sets the count to 0, and it overrides any enable or disable in the same cycle without raising err_o. The pads then power down as in R4.
- R9: A request that arrives while a sequence is running updates the count at once. If the running sequence no longer matches the count when it completes, the opposite sequence starts on the next cycle.
- R10: The count saturates at 255. After 256 enables, the 255th disable powers down and the 256th disable raises err_o.
- R11: enable_req and disable_req at 1 in the same cycle leave the count unchanged and do not raise err_o.
- R12: Only one control changes per cycle. early_clamp_o is never 0 while clamp_o is 1, and core_pd_o is never 0 while early_clamp_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_req | input | 1 | One-cycle pulse: a client acquires the pads |
| disable_req | input | 1 | One-cycle pulse: a client releases the pads |
| force_off | input | 1 | Empties the reference count |
| word_in | input | 32 | Control word whose other bits pass through |
| core_pd_o | output | 1 | Core power-down, 1 = powered down |
| early_clamp_o | output | 1 | Early clamp enable, 1 = clamped |
| clamp_o | output | 1 | Final clamp enable, 1 = clamped |
| word_out | output | 32 | word_in with bits 31..29 replaced by the three controls |
| busy_o | output | 1 | A power-up or power-down sequence is running |
| err_o | output | 1 | One-cycle pulse on an unbalanced disable |

## Verification
The count and err_o register at the edge that samples a request. The first control step follows one edge later, and each further step follows G cycles after the step before it. The bench drives requests on falling edges and reads the outputs on the falling edge right after each expected step. It also reads them one cycle before each step, to show that nothing moves early. The sweeps cover client counts from one to three and the saturation point. The bench uses a small gap of 6 cycles, so every step falls inside a short window.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_UP1, ST_UP2, ST_ON, ST_DN1, ST_DN2
  } seq_st_t;

  typedef struct packed {
    logic core_pd;
    logic early;
    logic clamp;
  } iso_t;

  function automatic iso_t iso_of(seq_st_t s);
    case (s)
      ST_UP1:  return '{core_pd: 1'b1, early: 1'b1, clamp: 1'b0};
      ST_UP2:  return '{core_pd: 1'b1, early: 1'b0, clamp: 1'b0};
      ST_ON:   return '{core_pd: 1'b0, early: 1'b0, clamp: 1'b0};
      ST_DN1:  return '{core_pd: 1'b1, early: 1'b0, clamp: 1'b0};
      ST_DN2:  return '{core_pd: 1'b1, early: 1'b1, clamp: 1'b0};
      default: return '{core_pd: 1'b1, early: 1'b1, clamp: 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/pcs_gap_timer.sv
module pcs_gap_timer #(
  parameter int CLKS_PER_US = 100,
  parameter int GAP_US      = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int US_W  = (GAP_US > 1) ? $clog2(GAP_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
  localparam logic [US_W-1:0]  US_LAST  = US_W'(GAP_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;
  logic             tick;

  assign tick    = (pre_q == PRE_LAST);
  assign expired = run && tick && (us_q == US_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (restart || !run) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      us_q  <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcs_refcount.sv
module pcs_refcount #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic force_off,
  output logic nonzero,
  output logic unbalanced
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign nonzero = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      unbalanced <= 1'b0;
    end else begin
      unbalanced <= 1'b0;
      if (force_off) begin
        cnt_q <= '0;
      end else if (inc && !dec) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc) begin
        if (cnt_q == '0) unbalanced <= 1'b1;
        else             cnt_q      <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcs_seq_fsm.sv
module pcs_seq_fsm
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_on,
  input  logic gap_done,
  output iso_t iso,
  output logic busy,
  output logic step
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    step = 1'b0;
    case (st_q)
      ST_OFF: if (want_on)  begin st_d = ST_UP1; step = 1'b1; end
      ST_UP1: if (gap_done) begin st_d = ST_UP2; step = 1'b1; end
      ST_UP2: if (gap_done) begin st_d = ST_ON;  step = 1'b1; end
      ST_ON:  if (!want_on) begin st_d = ST_DN1; step = 1'b1; end
      ST_DN1: if (gap_done) begin st_d = ST_DN2; step = 1'b1; end
      ST_DN2: if (gap_done) begin st_d = ST_OFF; step = 1'b1; end
      default: begin st_d = ST_OFF; step = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
      iso  <= iso_of(ST_OFF);
    end else begin
      st_q <= st_d;
      iso  <= iso_of(st_d);
    end
  end

  assign busy = (st_q != ST_OFF) && (st_q != ST_ON);
endmodule

// File: rtl/pad_clamp_seq.sv
module pad_clamp_seq
  import pcs_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int GAP_US      = 100,
  parameter int CNT_W       = 8,
  parameter int WORD_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_req,
  input  logic              disable_req,
  input  logic              force_off,
  input  logic [WORD_W-1:0] word_in,
  output logic              core_pd_o,
  output logic              early_clamp_o,
  output logic              clamp_o,
  output logic [WORD_W-1:0] word_out,
  output logic              busy_o,
  output logic              err_o
);
  localparam int PD_BIT    = WORD_W - 1;
  localparam int EARLY_BIT = WORD_W - 2;
  localparam int CLAMP_BIT = WORD_W - 3;

  logic want_on, gap_done, step, busy;
  iso_t iso;

  pcs_refcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(enable_req), .dec(disable_req),
    .force_off(force_off), .nonzero(want_on), .unbalanced(err_o)
  );

  pcs_gap_timer #(.CLKS_PER_US(CLKS_PER_US), .GAP_US(GAP_US)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(step), .expired(gap_done)
  );

  pcs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .want_on(want_on), .gap_done(gap_done),
    .iso(iso), .busy(busy), .step(step)
  );

  assign core_pd_o     = iso.core_pd;
  assign early_clamp_o = iso.early;
  assign clamp_o       = iso.clamp;
  assign busy_o        = busy;

  always_comb begin
    word_out            = word_in;
    word_out[PD_BIT]    = iso.core_pd;
    word_out[EARLY_BIT] = iso.early;
    word_out[CLAMP_BIT] = iso.clamp;
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk (
  input logic clk,
  input logic rst_n,
  input logic core_pd,
  input logic early,
  input logic clamp,
  input logic busy
);
  // R12
  order_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !early |-> !clamp);

  // R12
  order_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pd |-> !early);

  // R12
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({core_pd ^ $past(core_pd), early ^ $past(early),
                clamp ^ $past(clamp)}) <= 1);

  // R2
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp) |=> $stable(early));

  // R4
  busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == ({core_pd, early, clamp} != 3'b111 && {core_pd, early, clamp} != 3'b000));
endmodule

bind pad_clamp_seq pcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_pd(core_pd_o), .early(early_clamp_o),
  .clamp(clamp_o), .busy(busy_o)
);

// File: tb/tb_pad_clamp_seq.sv
`timescale 1ns/1ps
module tb_pad_clamp_seq;
  localparam int CPU = 2;
  localparam int GAP = 3;
  localparam int GC  = CPU * GAP;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dis = 1'b0, frc = 1'b0;
  logic [31:0] win = 32'h0ABC_DEF1;
  logic [31:0] wout;
  logic pd, early, clamp, busy, err;
  int n_chk = 0, n_err = 0;

  pad_clamp_seq #(.CLKS_PER_US(CPU), .GAP_US(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .enable_req(en), .disable_req(dis),
    .force_off(frc), .word_in(win), .core_pd_o(pd), .early_clamp_o(early),
    .clamp_o(clamp), .word_out(wout), .busy_o(busy), .err_o(err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [2:0] pat, input logic b);
    chk(tag, {28'd0, busy, pd, early, clamp}, {28'd0, b, pat});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic e, input logic d, input logic f);
    @(negedge clk); en = e; dis = d; frc = f;
    @(negedge clk); en = 0; dis = 0; frc = 0;
  endtask

  task automatic up_seq(input string tag);
    chk_out(tag, 3'b111, 0);
    wait_n(1);      chk_out(tag, 3'b110, 1);
    wait_n(GC - 1); chk_out(tag, 3'b110, 1);
    wait_n(1);      chk_out(tag, 3'b100, 1);
    wait_n(GC - 1); chk_out(tag, 3'b100, 1);
    wait_n(1);      chk_out(tag, 3'b000, 0);
  endtask

  task automatic dn_seq(input string tag);
    chk_out(tag, 3'b000, 0);
    wait_n(1);      chk_out(tag, 3'b100, 1);
    wait_n(GC - 1); chk_out(tag, 3'b100, 1);
    wait_n(1);      chk_out(tag, 3'b110, 1);
    wait_n(GC - 1); chk_out(tag, 3'b110, 1);
    wait_n(1);      chk_out(tag, 3'b111, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    wait_n(3);
    chk_out("R1 in reset", 3'b111, 0);
    chk("R1 err", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    wait_n(3);
    chk_out("R1 after reset", 3'b111, 0);
    chk("R7 word off", wout, {3'b111, win[28:0]});

    // R2, R3, R5, R4: sweep over client counts
    for (int n = 1; n <= 3; n++) begin
      pulse(1, 0, 0);
      up_seq("R2");
      for (int k = 2; k <= n; k++) begin
        pulse(1, 0, 0);
        chk_out("R3", 3'b000, 0);
        wait_n(3); chk_out("R3", 3'b000, 0);
      end
      if (n == 1) begin
        win = 32'hFFFF_FFFF; wait_n(1);
        chk("R7 word on", wout, 32'h1FFF_FFFF);
        win = 32'h0ABC_DEF1;
      end
      for (int k = 1; k < n; k++) begin
        pulse(0, 1, 0);
        wait_n(3); chk_out("R5", 3'b000, 0);
      end
      pulse(0, 1, 0);
      dn_seq("R4");
    end

    // R6 unbalanced disable
    pulse(0, 1, 0);
    chk("R6 err", {31'd0, err}, 32'd1);
    chk_out("R6 outputs", 3'b111, 0);
    wait_n(1); chk("R6 err one cycle", {31'd0, err}, 32'd0);
    pulse(1, 0, 0); up_seq("R6");
    pulse(0, 1, 0); chk("R6 no err", {31'd0, err}, 32'd0);
    dn_seq("R6");

    // R11 simultaneous requests
    pulse(1, 1, 0);
    chk("R11 err", {31'd0, err}, 32'd0);
    wait_n(4); chk_out("R11 off", 3'b111, 0);
    pulse(1, 0, 0); wait_n(2 * GC + 2);
    pulse(1, 1, 0); wait_n(4); chk_out("R11 on", 3'b000, 0);
    pulse(0, 1, 0); dn_seq("R11");

    // R9 disable during power-up
    pulse(1, 0, 0); wait_n(1);
    chk_out("R9 busy", 3'b110, 1);
    pulse(0, 1, 0);
    for (int i = 0; i < 3 * GC && pd !== 1'b0; i++) wait_n(1);
    chk_out("R9 reached on", 3'b000, 0);
    wait_n(1);  chk_out("R9 down", 3'b100, 1);
    wait_n(GC); chk_out("R9 down", 3'b110, 1);
    wait_n(GC); chk_out("R9 down", 3'b111, 0);

    // R8 force off overrides enable
    for (int i = 0; i < 3; i++) pulse(1, 0, 0);
    wait_n(2 * GC + 2); chk_out("R8 on", 3'b000, 0);
    pulse(1, 0, 1);
    chk("R8 err", {31'd0, err}, 32'd0);
    dn_seq("R8");
    pulse(0, 1, 0);
    chk("R8 count zero", {31'd0, err}, 32'd1);

    // R10 saturation
    for (int i = 0; i < 256; i++) pulse(1, 0, 0);
    wait_n(2 * GC + 2); chk_out("R10 on", 3'b000, 0);
    for (int i = 0; i < 254; i++) pulse(0, 1, 0);
    wait_n(3); chk_out("R10 still on", 3'b000, 0);
    pulse(0, 1, 0); dn_seq("R10");
    pulse(0, 1, 0);
    chk("R10 err", {31'd0, err}, 32'd1);

    summary();
  end
endmodule